// File: doc/BRIEF.md
# Inductive Charger Fault Supervisor

This block is the top-level control state machine of an inductive power transmitter. It chooses among shutdown, standby pinging, power transfer and a set of recovery states. The choice depends on an active-low enable, a receiver-detected strobe, a receiver-removed strobe, a decoded end-of-transfer reason and five comparator flags. The comparator flags cover input over-current, input over-voltage, input under-voltage, thermistor below its trip level and thermistor above its release level. It drives the bridge enable, one-cycle analog and digital ping requests for a separate ping generator, and a 2-bit status code for the indicator logic.

Each fault type has its own recovery policy. Over-current and under-voltage start a lockout that counts pulses of a slow external tick. Over-voltage holds until the input is back in range. Over-temperature holds with hysteresis. End-of-transfer requests either restart full pinging, or mute digital pings for one lockout and then allow a single digital ping. One lockout timer is shared by all timed states and is reloaded on each entry. Enable and the comparator flags pass through two-flop synchronizers. The strobes and the tick are taken as already in the clock domain. A reset stands for an input power cycle and clears every lockout.

Top module: `wsup_top`

## Requirements
- R1: While `en_n` is high (after synchronization) the block is in shutdown: `bridge_en`, `aping_req` and `dping_req` are 0 and `status` is 2'b00. The same holds directly after reset.
- R2: With enable low and no receiver, the block pings in standby. A ping event occurs every `PING_GAP` clocks, and the events alternate analog, digital, analog and so on. `aping_req` and `dping_req` are never high in the same cycle.
- R3: An over-current flag during transfer clears `bridge_en` on the third rising edge after the flag is set, and `status` becomes 2'b11. Only analog pings run during the lockout. After `LOCK_TICKS` tick pulses the block returns to standby with digital pings.
- R4: An over-current during the transfer that follows an over-current lockout, with no receiver removal or end-of-transfer request in between, enters a degraded state. In that state only analog pings run, with no timed exit, and `status` is 2'b11.
- R5: A receiver-removed strobe during any lockout or degraded state moves to standby at the next edge (`status` 2'b00), and digital pinging resumes.
- R6: An under-voltage flag outside shutdown stops the bridge and all pings with `status` 2'b11, for `LOCK_TICKS` tick pulses. The block then returns to standby.
- R7: An over-voltage flag is ignored during transfer. In standby it stops all pings with `status` 2'b11 until the flag clears, and standby resumes on the third edge after the flag clears.
- R8: During transfer, the below-trip thermistor flag stops the bridge (`status` 2'b11). Transfer resumes only when the above-release flag is set; clearing the trip flag alone has no effect.
- R9: `ept_code` values: 1 charge complete, 2 internal fault, 3 over-temperature, 4 over-current. Codes 2 and 4 and any undefined code stop the bridge and return to standby with both ping kinds running (`status` 2'b00).
- R10: Codes 1 and 3 stop the bridge and run analog pings only for `LOCK_TICKS` tick pulses. When that window ends, exactly one `dping_req` pulse is issued, and the block stays analog-only until the receiver is found or removed.
- R11: `status` encoding: 2'b00 standby or shutdown, 2'b01 transfer, 2'b10 charge complete, 2'b11 fault. The muted state reports 2'b10 after code 1 and 2'b11 after code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable, asynchronous |
| rx_found | input | 1 | One-cycle strobe: receiver answered a digital ping |
| rx_gone | input | 1 | One-cycle strobe: receiver removed |
| ept_valid | input | 1 | One-cycle strobe qualifying `ept_code` |
| ept_code | input | 3 | End-of-transfer reason code |
| ovc_flag | input | 1 | Input over-current comparator, asynchronous |
| ovv_flag | input | 1 | Input over-voltage comparator, asynchronous |
| unv_flag | input | 1 | Input under-voltage comparator, asynchronous |
| ts_hot | input | 1 | Thermistor below trip level, asynchronous |
| ts_cool | input | 1 | Thermistor above release level, asynchronous |
| lk_tick | input | 1 | One-cycle pulse of the slow lockout timebase |
| bridge_en | output | 1 | Power bridge enable |
| aping_req | output | 1 | One-cycle analog ping request |
| dping_req | output | 1 | One-cycle digital ping request |
| status | output | 2 | Indicator status code |

## Verification
Flag-driven results are due on the third rising edge after a flag changes: two synchronizer stages, then the state register. Strobe-driven results are due at the first edge. The bench drives every input at a falling edge and samples at the falling edge just before the due edge and just after it, so each latency is pinned from both sides. A timed exit is due one edge after the edge that takes the final tick. The bench checks the state after `LOCK_TICKS-1` ticks, gives the last tick, and checks again one cycle later. Ping requests are counted at falling edges over windows of four ping gaps. Each pulse is therefore seen exactly once, and presence, absence and the single post-mute digital ping are all decided from the counts.

// File: rtl/wsup_pkg.sv
package wsup_pkg;

    typedef enum logic [3:0] {
        S_SHUT,
        S_STBY,
        S_XFER,
        S_OCLK,
        S_DEGR,
        S_UVLK,
        S_OVHD,
        S_OTHD,
        S_MUTE,
        S_PARK
    } sup_state_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_XFER  = 2'b01,
        ST_DONE  = 2'b10,
        ST_FAULT = 2'b11
    } stat_e;

    localparam logic [2:0] EPT_DONE = 3'd1;
    localparam logic [2:0] EPT_INTF = 3'd2;
    localparam logic [2:0] EPT_HOT  = 3'd3;
    localparam logic [2:0] EPT_OVC  = 3'd4;

    typedef struct packed {
        logic en_n;
        logic ovc;
        logic ovv;
        logic unv;
        logic hot;
        logic cool;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);
    localparam flags_t FL_RST = '{en_n: 1'b1, default: 1'b0};

    function automatic stat_e status_of(sup_state_e s, logic hot_park);
        case (s)
            S_SHUT, S_STBY: return ST_IDLE;
            S_XFER:         return ST_XFER;
            S_MUTE, S_PARK: return hot_park ? ST_FAULT : ST_DONE;
            default:        return ST_FAULT;
        endcase
    endfunction

    function automatic logic is_timed(sup_state_e s);
        return (s == S_OCLK) || (s == S_UVLK) || (s == S_MUTE);
    endfunction

endpackage

// File: rtl/wsup_sync.sv
module wsup_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            d_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/wsup_timer.sv
module wsup_timer #(
    parameter int TICKS = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic          active;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            expire <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (active && tick) begin
                if (cnt == LAST) begin
                    active <= 1'b0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wsup_pinger.sv
module wsup_pinger #(
    parameter int GAP = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic allow_a,
    input  logic allow_d,
    input  logic one_d,
    output logic a_req,
    output logic d_req
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);

    logic          run;
    logic          wrap;
    logic          slot;
    logic [CW-1:0] cnt;

    assign run  = allow_a | allow_d;
    assign wrap = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            slot <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            slot <= ~slot;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_req <= 1'b0;
            d_req <= 1'b0;
        end else begin
            a_req <= wrap && !slot && allow_a && !one_d;
            d_req <= (wrap && slot && allow_d) || one_d;
        end
    end
endmodule

// File: rtl/wsup_fsm.sv
module wsup_fsm
    import wsup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flags_t     fl,
    input  logic       rx_found,
    input  logic       rx_gone,
    input  logic       ept_valid,
    input  logic [2:0] ept_code,
    input  logic       lk_expire,
    output sup_state_e st,
    output logic       bridge,
    output logic       allow_a,
    output logic       allow_d,
    output logic       one_d,
    output logic       lk_start,
    output stat_e      stat
);
    sup_state_e nxt;
    logic       strike, nstrike;
    logic       hot_park, nhot;

    always_comb begin
        nxt     = st;
        nstrike = strike;
        nhot    = hot_park;
        one_d   = 1'b0;
        if (fl.en_n) begin
            nxt     = S_SHUT;
            nstrike = 1'b0;
        end else if (fl.unv && st != S_UVLK) begin
            nxt = S_UVLK;
        end else begin
            case (st)
                S_SHUT: nxt = S_STBY;
                S_STBY: begin
                    if (fl.ovv)        nxt = S_OVHD;
                    else if (rx_found) nxt = S_XFER;
                end
                S_XFER: begin
                    if (fl.ovc) begin
                        if (strike) nxt = S_DEGR;
                        else begin
                            nxt     = S_OCLK;
                            nstrike = 1'b1;
                        end
                    end else if (fl.hot) begin
                        nxt = S_OTHD;
                    end else if (ept_valid) begin
                        nstrike = 1'b0;
                        case (ept_code)
                            EPT_DONE: begin nxt = S_MUTE; nhot = 1'b0; end
                            EPT_HOT:  begin nxt = S_MUTE; nhot = 1'b1; end
                            default:  nxt = S_STBY;
                        endcase
                    end
                end
                S_OCLK, S_DEGR: begin
                    if (rx_gone) begin
                        nxt     = S_STBY;
                        nstrike = 1'b0;
                    end else if (lk_expire && st == S_OCLK) begin
                        nxt = S_STBY;
                    end
                end
                S_UVLK: begin
                    if (rx_gone || lk_expire) nxt = S_STBY;
                end
                S_OVHD: begin
                    if (!fl.ovv) nxt = S_STBY;
                end
                S_OTHD: begin
                    if (fl.cool) nxt = S_XFER;
                end
                S_MUTE: begin
                    if (rx_gone) nxt = S_STBY;
                    else if (lk_expire) begin
                        nxt   = S_PARK;
                        one_d = 1'b1;
                    end
                end
                S_PARK: begin
                    if (rx_gone)       nxt = S_STBY;
                    else if (rx_found) nxt = S_XFER;
                end
                default: nxt = S_SHUT;
            endcase
        end
    end

    assign lk_start = is_timed(nxt) && (nxt != st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_SHUT;
            strike   <= 1'b0;
            hot_park <= 1'b0;
        end else begin
            st       <= nxt;
            strike   <= nstrike;
            hot_park <= nhot;
        end
    end

    assign bridge  = (st == S_XFER);
    assign allow_d = (st == S_STBY);
    assign allow_a = (st == S_STBY) || (st == S_OCLK) || (st == S_DEGR) ||
                     (st == S_MUTE) || (st == S_PARK);
    assign stat    = status_of(st, hot_park);
endmodule

// File: rtl/wsup_top.sv
module wsup_top
    import wsup_pkg::*;
#(
    parameter int PING_GAP   = 50000,
    parameter int LOCK_TICKS = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_n,
    input  logic       rx_found,
    input  logic       rx_gone,
    input  logic       ept_valid,
    input  logic [2:0] ept_code,
    input  logic       ovc_flag,
    input  logic       ovv_flag,
    input  logic       unv_flag,
    input  logic       ts_hot,
    input  logic       ts_cool,
    input  logic       lk_tick,
    output logic       bridge_en,
    output logic       aping_req,
    output logic       dping_req,
    output logic [1:0] status
);
    flags_t     fl_raw;
    flags_t     fl_s;
    logic [FLAG_W-1:0] fl_vec;
    sup_state_e st_w;
    stat_e      stat_w;
    logic       allow_a, allow_d, one_d, lk_start, lk_expire;

    assign fl_raw = '{en_n: en_n, ovc: ovc_flag, ovv: ovv_flag,
                      unv: unv_flag, hot: ts_hot, cool: ts_cool};

    wsup_sync #(.W(FLAG_W), .RST_VAL(FL_RST)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (fl_raw),
        .d_sync  (fl_vec)
    );
    assign fl_s = flags_t'(fl_vec);

    wsup_timer #(.TICKS(LOCK_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (lk_start),
        .tick   (lk_tick),
        .expire (lk_expire)
    );

    wsup_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .fl        (fl_s),
        .rx_found  (rx_found),
        .rx_gone   (rx_gone),
        .ept_valid (ept_valid),
        .ept_code  (ept_code),
        .lk_expire (lk_expire),
        .st        (st_w),
        .bridge    (bridge_en),
        .allow_a   (allow_a),
        .allow_d   (allow_d),
        .one_d     (one_d),
        .lk_start  (lk_start),
        .stat      (stat_w)
    );

    wsup_pinger #(.GAP(PING_GAP)) u_ping (
        .clk     (clk),
        .rst     (rst),
        .allow_a (allow_a),
        .allow_d (allow_d),
        .one_d   (one_d),
        .a_req   (aping_req),
        .d_req   (dping_req)
    );

    assign status = stat_w;
endmodule

// File: rtl/wsup_chk.sv
module wsup_chk
    import wsup_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input sup_state_e st,
    input flags_t     fl,
    input logic       bridge_en,
    input logic       aping_req,
    input logic       dping_req,
    input logic [1:0] status
);
    // R1
    shut_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        st == S_SHUT |-> !bridge_en && status == 2'b00);

    // R1
    shut_noping_chk: assert property (@(posedge clk) disable iff (rst)
        st == S_SHUT |=> !aping_req && !dping_req);

    // R2
    ping_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(aping_req && dping_req));

    // R3
    ovc_stop_chk: assert property (@(posedge clk) disable iff (rst)
        bridge_en && fl.ovc |=> !bridge_en);

    // R4
    degr_nodig_chk: assert property (@(posedge clk) disable iff (rst)
        st == S_DEGR |-> !dping_req);

    // R6
    unv_enter_chk: assert property (@(posedge clk) disable iff (rst)
        fl.unv && !fl.en_n && st != S_UVLK |=> st == S_UVLK);

    // R8
    hot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        bridge_en && fl.hot |=> !bridge_en);

    // R10
    park_single_chk: assert property (@(posedge clk) disable iff (rst)
        st == S_PARK && $past(st) == S_PARK |-> !dping_req);
endmodule

bind wsup_top wsup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (st_w),
    .fl        (fl_s),
    .bridge_en (bridge_en),
    .aping_req (aping_req),
    .dping_req (dping_req),
    .status    (status)
);

// File: tb/sim_wsup_top.sv
module sim_wsup_top;
    localparam int CLK_P = 10;
    localparam int GAP   = 8;
    localparam int TICKS = 4;
    localparam int WIN   = 4 * GAP;

    typedef struct packed {
        logic [2:0] code;
        logic [1:0] stat;
        logic       a_on;
        logic       d_on;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{code: 3'd1, stat: 2'b10, a_on: 1'b1, d_on: 1'b0},
        '{code: 3'd2, stat: 2'b00, a_on: 1'b1, d_on: 1'b1},
        '{code: 3'd3, stat: 2'b11, a_on: 1'b1, d_on: 1'b0},
        '{code: 3'd4, stat: 2'b00, a_on: 1'b1, d_on: 1'b1},
        '{code: 3'd6, stat: 2'b00, a_on: 1'b1, d_on: 1'b1}
    };

    logic clk = 0, rst = 1;
    logic en_n = 1, rx_found = 0, rx_gone = 0, ept_valid = 0;
    logic [2:0] ept_code = 0;
    logic ovc_flag = 0, ovv_flag = 0, unv_flag = 0, ts_hot = 0, ts_cool = 0;
    logic lk_tick = 0;
    logic bridge_en, aping_req, dping_req;
    logic [1:0] status;

    int total = 0, bad = 0;
    int a_cnt = 0, d_cnt = 0, both_cnt = 0;
    bit counting = 0, finished = 0;

    always #(CLK_P/2) clk = ~clk;

    wsup_top #(.PING_GAP(GAP), .LOCK_TICKS(TICKS)) u0 (
        .clk(clk), .rst(rst), .en_n(en_n), .rx_found(rx_found), .rx_gone(rx_gone),
        .ept_valid(ept_valid), .ept_code(ept_code), .ovc_flag(ovc_flag),
        .ovv_flag(ovv_flag), .unv_flag(unv_flag), .ts_hot(ts_hot), .ts_cool(ts_cool),
        .lk_tick(lk_tick), .bridge_en(bridge_en), .aping_req(aping_req),
        .dping_req(dping_req), .status(status)
    );

    always @(negedge clk) if (counting) begin
        a_cnt    += int'(aping_req);
        d_cnt    += int'(dping_req);
        both_cnt += int'(aping_req && dping_req);
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_found(); rx_found = 1; cyc(1); rx_found = 0; endtask
    task automatic strobe_gone();  rx_gone  = 1; cyc(1); rx_gone  = 0; endtask

    task automatic send_ept(logic [2:0] c);
        ept_code = c; ept_valid = 1; cyc(1); ept_valid = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            lk_tick = 1; cyc(1); lk_tick = 0; cyc(1);
        end
    endtask

    task automatic window(int n);
        a_cnt = 0; d_cnt = 0; both_cnt = 0;
        counting = 1; cyc(n); counting = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset and shutdown state
        check("R1 reset bridge", bridge_en, 0);
        check("R1 reset status", status, 0);
        window(WIN);
        check("R1 shutdown pings", a_cnt + d_cnt, 0);
        en_n = 0;
        cyc(3);
        // R2 standby alternates both kinds, never together
        window(WIN);
        check("R2 analog seen", a_cnt > 0, 1);
        check("R2 digital seen", d_cnt > 0, 1);
        check("R2 alternation", a_cnt - d_cnt <= 1 && d_cnt - a_cnt <= 1, 1);
        check("R2 exclusive", both_cnt, 0);

        // R9 R11 table of end-of-transfer reasons
        foreach (VEC[i]) begin
            strobe_gone();
            strobe_found();
            check("R11 transfer status", status, 1);
            check("R9 transfer bridge", bridge_en, 1);
            send_ept(VEC[i].code);
            check("R9 bridge off after ept", bridge_en, 0);
            check("R11 status after ept", status, VEC[i].stat);
            window(WIN);
            check("R9 analog policy", a_cnt > 0, VEC[i].a_on);
            check("R10 digital policy", d_cnt > 0, VEC[i].d_on);
        end
        strobe_gone();

        // R3 over-current lockout
        strobe_found();
        ovc_flag = 1;
        cyc(2);
        check("R3 bridge before due edge", bridge_en, 1);
        cyc(1);
        check("R3 bridge off", bridge_en, 0);
        check("R3 fault status", status, 3);
        ovc_flag = 0;
        window(WIN);
        check("R3 no digital in lockout", d_cnt, 0);
        check("R3 analog in lockout", a_cnt > 0, 1);
        ticks(TICKS - 1);
        check("R3 still locked", status, 3);
        ticks(1);
        check("R3 standby after lockout", status, 0);
        window(WIN);
        check("R3 digital retried", d_cnt > 0, 1);

        // R4 second consecutive over-current
        strobe_found();
        ovc_flag = 1;
        cyc(3);
        check("R4 bridge off", bridge_en, 0);
        ovc_flag = 0;
        ticks(TICKS + 1);
        window(WIN);
        check("R4 degraded status", status, 3);
        check("R4 no digital", d_cnt, 0);
        check("R4 analog continues", a_cnt > 0, 1);
        // R5 removal leaves degraded state
        strobe_gone();
        check("R5 standby after removal", status, 0);
        window(WIN);
        check("R5 digital resumes", d_cnt > 0, 1);

        // R5 removal during timed lockout
        strobe_found();
        ovc_flag = 1;
        cyc(3);
        ovc_flag = 0;
        check("R5 locked", status, 3);
        strobe_gone();
        check("R5 immediate standby", status, 0);
        window(WIN);
        check("R5 digital after removal", d_cnt > 0, 1);

        // R6 under-voltage lockout
        unv_flag = 1;
        cyc(3);
        check("R6 fault status", status, 3);
        unv_flag = 0;
        window(WIN);
        check("R6 no pings", a_cnt + d_cnt, 0);
        ticks(TICKS - 1);
        check("R6 still locked", status, 3);
        ticks(1);
        check("R6 standby after lockout", status, 0);

        // R7 over-voltage ignored during transfer, held in standby
        strobe_found();
        ovv_flag = 1;
        cyc(6);
        check("R7 ignored in transfer", bridge_en, 1);
        send_ept(3'd2);
        check("R7 standby first", status, 0);
        cyc(1);
        check("R7 hold status", status, 3);
        window(WIN);
        check("R7 no pings in hold", a_cnt + d_cnt, 0);
        ovv_flag = 0;
        cyc(2);
        check("R7 hold before due edge", status, 3);
        cyc(1);
        check("R7 standby after clear", status, 0);

        // R8 thermal hysteresis
        strobe_found();
        ts_hot = 1;
        cyc(2);
        check("R8 bridge before due edge", bridge_en, 1);
        cyc(1);
        check("R8 bridge off hot", bridge_en, 0);
        check("R8 fault status", status, 3);
        ts_hot = 0;
        cyc(5);
        check("R8 no resume without release", bridge_en, 0);
        ts_cool = 1;
        cyc(2);
        check("R8 still off before due edge", bridge_en, 0);
        cyc(1);
        check("R8 resumed", bridge_en, 1);
        ts_cool = 0;
        send_ept(3'd2);

        // R10 muted window then exactly one digital ping
        strobe_found();
        send_ept(3'd1);
        a_cnt = 0; d_cnt = 0; both_cnt = 0;
        counting = 1;
        ticks(TICKS);
        cyc(WIN);
        counting = 0;
        check("R10 single digital ping", d_cnt, 1);
        check("R10 status complete", status, 2);
        check("R10 bridge off", bridge_en, 0);
        check("R2 exclusive in mute", both_cnt, 0);
        strobe_gone();

        // R1 enable high again
        en_n = 1;
        cyc(3);
        window(WIN);
        check("R1 shutdown status", status, 0);
        check("R1 shutdown pings", a_cnt + d_cnt, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule